// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces a Repeated Start condition on a pair of open-drain I2C lines for a bus master. Software writes a request bit into a five-bit event control register. While no other event is pending, the block takes the request and walks the lines through a fixed series of phases. First it pulls SCL low. It then releases SDA, releases SCL, holds both lines high, and finally pulls SDA low while SCL stays high. A reload counter loaded from a 7-bit divisor times each phase. Every phase ends only after the line the block has released is seen high, so a slave that stretches the clock only lengthens the sequence. When the sequence finishes, the block clears the request bit itself, keeps SDA held low and raises a completion interrupt flag.

The block reads the resolved lines back through a two-flop synchronizer. It watches them for arbitration loss and for any start condition on the bus. A write to the transmit buffer during the sequence is refused and sets a write-collision flag. Writes to the event control register are ignored for the whole sequence, so no event can be queued behind it.

The state machine has six states. ST_IDLE goes to ST_SCL_LOW on an accepted request. ST_SCL_LOW goes to ST_SDA_REL once SCL is seen low. ST_SDA_REL goes to ST_SCL_REL once its period has timed out and SDA is seen high. ST_SCL_REL goes to ST_HIGH_HOLD when SCL is seen high with SDA high, or to ST_IDLE with a collision when SDA is low. ST_HIGH_HOLD goes to ST_SDA_LOW on timeout, or to ST_IDLE with a collision if SCL is seen low. ST_SDA_LOW goes to ST_IDLE with completion on timeout.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A write that sets the request bit (bit 1 of the event control register) is accepted only when the block is idle, no other event bit (bits 0, 2, 3, 4) is set in the register, and none is set in the written value. A refused request leaves the request bit clear and does not touch the lines. While idle, the other written bits are stored.
- R2: On acceptance the block pulls SCL low. It reacts to any line change on the third clock after that change. Once SCL is seen low, it releases SDA and holds SCL low for one baud period of (divisor + 1) clocks. If SDA was already released, the SCL-driven, SDA-released interval lasts divisor + 4 clocks. If SDA was held, the interval lasts max(divisor + 1, 3) clocks.
- R3: SCL is released only after the baud period has timed out and SDA is seen high. Both lines then stay released for 3 clocks plus one baud period, counted once SCL is really high.
- R4: SDA is then pulled low for exactly one baud period while SCL stays released. On the clock that ends this period, the completion interrupt flag sets and the request bit clears, and SDA stays held low afterwards.
- R5: The start-seen status sets within four clocks of SDA falling while SCL is high. It clears when SDA rises while SCL is high. It is 0 after reset.
- R6: If another device holds SCL low for N clocks after the block releases it, the high phase grows by exactly N clocks and the sequence still completes without a collision.
- R7: A bus collision is flagged in two cases: SDA is seen low when SCL is seen going high, or SCL is seen low before SDA has been pulled low. On a collision the block releases both lines, clears the request bit, returns to idle and does not set the interrupt flag.
- R8: A transmit-buffer write during the sequence sets the write-collision flag and leaves the buffer unchanged. A write while idle updates the buffer.
- R9: Writes to the event control register during the sequence have no effect.
- R10: The interrupt, bus-collision and write-collision flags stay set until cleared through flag_clr. Bit 0 clears the interrupt flag, bit 1 clears the bus-collision flag and bit 2 clears the write-collision flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 7 | Baud divisor; one period is div_val + 1 clocks |
| ctl_wr | input | 1 | Write strobe for the event control register |
| ctl_wdata | input | 5 | Event control write data; bit 1 requests a Repeated Start |
| ctl_q | output | 5 | Event control register contents |
| txb_wr | input | 1 | Transmit buffer write strobe |
| txb_wdata | input | 8 | Transmit buffer write data |
| txb_q | output | 8 | Transmit buffer contents |
| flag_clr | input | 3 | Clear strobes: bit 0 interrupt, bit 1 bus collision, bit 2 write collision |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| start_seen | output | 1 | A start condition has been seen on the bus |
| irq_flag | output | 1 | Sticky completion interrupt flag |
| bcol_flag | output | 1 | Sticky bus-collision flag |
| wcol_flag | output | 1 | Sticky write-collision flag |

## Verification
A wrong state or a missed transition shows up at once on scl_oe and sda_oe. A phase that is too long or too short changes the number of clocks the lines spend in a given drive pattern, and the bench counts these to the exact clock in each phase. A lost or misplaced reload shows as an off-by-one in the phase lengths, which the bench exercises with divisors from 0 to 127. A collision path that fails to release the lines or clear the request shows within a few clocks as a line still driven, ctl_q still set, or a stray interrupt flag.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCL_LOW,
        ST_SDA_REL,
        ST_SCL_REL,
        ST_HIGH_HOLD,
        ST_SDA_LOW
    } rs_state_e;

    localparam int FLAG_IRQ  = 0;
    localparam int FLAG_BCOL = 1;
    localparam int FLAG_WCOL = 2;
    localparam int N_FLAGS   = 3;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int N_LINES  = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw[g]};
            end
        end

        assign synced[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         tmo
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tmo = (cnt == '0);

endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
    import i2c_rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic scl_s,
    input  logic sda_s,
    input  logic tmo,
    output logic ld,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done_ev,
    output logic bcol_ev
);

    rs_state_e st, st_nx;
    logic      hold, hold_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            hold <= 1'b0;
        end else begin
            st   <= st_nx;
            hold <= hold_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        hold_nx = hold;
        ld      = 1'b0;
        done_ev = 1'b0;
        bcol_ev = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (go) begin
                    st_nx = ST_SCL_LOW;
                end
            end
            ST_SCL_LOW: begin
                if (!scl_s) begin
                    st_nx   = ST_SDA_REL;
                    ld      = 1'b1;
                    hold_nx = 1'b0;
                end
            end
            ST_SDA_REL: begin
                if (tmo && sda_s) begin
                    st_nx = ST_SCL_REL;
                end
            end
            ST_SCL_REL: begin
                if (scl_s) begin
                    if (sda_s) begin
                        st_nx = ST_HIGH_HOLD;
                        ld    = 1'b1;
                    end else begin
                        st_nx   = ST_IDLE;
                        bcol_ev = 1'b1;
                    end
                end
            end
            ST_HIGH_HOLD: begin
                if (!scl_s) begin
                    st_nx   = ST_IDLE;
                    bcol_ev = 1'b1;
                end else if (tmo) begin
                    st_nx = ST_SDA_LOW;
                    ld    = 1'b1;
                end
            end
            ST_SDA_LOW: begin
                if (tmo) begin
                    st_nx   = ST_IDLE;
                    done_ev = 1'b1;
                    hold_nx = 1'b1;
                end
            end
            default: begin
                st_nx   = ST_IDLE;
                hold_nx = 1'b0;
            end
        endcase
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        busy   = 1'b1;
        unique case (st)
            ST_IDLE: begin
                sda_oe = hold;
                busy   = 1'b0;
            end
            ST_SCL_LOW: begin
                scl_oe = 1'b1;
                sda_oe = hold;
            end
            ST_SDA_REL: begin
                scl_oe = 1'b1;
            end
            ST_SCL_REL, ST_HIGH_HOLD: begin
                scl_oe = 1'b0;
            end
            ST_SDA_LOW: begin
                sda_oe = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // R2
    sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> scl_oe);

    // R3
    scl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $past(sda_s));

    // R4
    sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> ($past(scl_s) && !scl_oe));

    // R7
    bcol_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcol_ev |=> (!scl_oe && !sda_oe && !busy));

endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
    import i2c_rs_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int CTL_W       = 5,
    parameter int RS_BIT      = 1,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic              txb_wr,
    input  logic [DATA_W-1:0] txb_wdata,
    output logic [DATA_W-1:0] txb_q,
    input  logic [2:0]        flag_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              start_seen,
    output logic              irq_flag,
    output logic              bcol_flag,
    output logic              wcol_flag
);

    localparam logic [CTL_W-1:0] RS_MASK = CTL_W'(1) << RS_BIT;

    logic [N_LINES-1:0] raw_lines, syn_lines;
    logic               scl_s, sda_s, scl_p, sda_p;
    logic               go, ld, tmo, busy, done_ev, bcol_ev;
    logic [N_FLAGS-1:0] flags, flag_set;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    i2c_line_sync #(
        .LINES  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_lines),
        .synced (syn_lines)
    );

    assign scl_s = syn_lines[LINE_SCL];
    assign sda_s = syn_lines[LINE_SDA];

    i2c_baud_cnt #(
        .W (DIV_W)
    ) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld),
        .ld_val (div_val),
        .tmo    (tmo)
    );

    assign go = ctl_wr && !busy && ctl_wdata[RS_BIT]
             && ((ctl_q & ~RS_MASK) == '0)
             && ((ctl_wdata & ~RS_MASK) == '0);

    i2c_rs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .tmo     (tmo),
        .ld      (ld),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe),
        .busy    (busy),
        .done_ev (done_ev),
        .bcol_ev (bcol_ev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr && !busy) begin
            ctl_q <= (ctl_wdata & ~RS_MASK) | (go ? RS_MASK : '0);
        end else if (done_ev || bcol_ev) begin
            ctl_q <= ctl_q & ~RS_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txb_q <= '0;
        end else if (txb_wr && !busy) begin
            txb_q <= txb_wdata;
        end
    end

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_IRQ]  = done_ev;
        flag_set[FLAG_BCOL] = bcol_ev;
        flag_set[FLAG_WCOL] = txb_wr && busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    assign irq_flag  = flags[FLAG_IRQ];
    assign bcol_flag = flags[FLAG_BCOL];
    assign wcol_flag = flags[FLAG_WCOL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p      <= 1'b1;
            sda_p      <= 1'b1;
            start_seen <= 1'b0;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (scl_s && scl_p && sda_p && !sda_s) begin
                start_seen <= 1'b1;
            end else if (scl_s && scl_p && !sda_p && sda_s) begin
                start_seen <= 1'b0;
            end
        end
    end

    // R8
    txb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && txb_wr) |=> $stable(txb_q));

    // R9
    ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr && !done_ev && !bcol_ev) |=> $stable(ctl_q));

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(done_ev));

endmodule

// File: tb/i2c_rstart_seq_bench.sv
module i2c_rstart_seq_bench;

    localparam int DIV_W  = 7;
    localparam int CTL_W  = 5;
    localparam int DATA_W = 8;
    localparam int LIMIT  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  div_val = '0;
    logic              ctl_wr = 1'b0;
    logic [CTL_W-1:0]  ctl_wdata = '0;
    logic [CTL_W-1:0]  ctl_q;
    logic              txb_wr = 1'b0;
    logic [DATA_W-1:0] txb_wdata = '0;
    logic [DATA_W-1:0] txb_q;
    logic [2:0]        flag_clr = '0;
    logic              scl_in, sda_in, scl_oe, sda_oe;
    logic              pull_scl = 1'b0;
    logic              pull_sda = 1'b0;
    logic              start_seen, irq_flag, bcol_flag, wcol_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    assign scl_in = ~scl_oe & ~pull_scl;
    assign sda_in = ~sda_oe & ~pull_sda;

    i2c_rstart_seq u_i2c_rstart_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_val    (div_val),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_q      (ctl_q),
        .txb_wr     (txb_wr),
        .txb_wdata  (txb_wdata),
        .txb_q      (txb_q),
        .flag_clr   (flag_clr),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .start_seen (start_seen),
        .irq_flag   (irq_flag),
        .bcol_flag  (bcol_flag),
        .wcol_flag  (wcol_flag)
    );

    function automatic int exp_rel(input int dv, input int held);
        if (held != 0) return (dv + 1 > 3) ? dv + 1 : 3;
        return dv + 4;
    endfunction

    function automatic int exp_high(input int dv, input int st);
        return 3 + st + dv + 1;
    endfunction

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [CTL_W-1:0] d);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic run_seq(input int dv, input int st);
        int held, n, m, k, guard;
        logic [DATA_W-1:0] old_txb;
        held = sda_oe;
        old_txb = txb_q;
        div_val = DIV_W'(dv);
        write_ctl(5'b00010);
        chk_eq("R2 scl pulled after request", scl_oe, 1);
        ctl_wr = 1'b1;
        ctl_wdata = 5'b11111;
        txb_wr = 1'b1;
        txb_wdata = ~old_txb;
        n = (scl_oe && !sda_oe) ? 1 : 0;
        @(negedge clk);
        ctl_wr = 1'b0;
        txb_wr = 1'b0;
        chk_eq("R9 ctl write while busy", ctl_q, 5'b00010);
        chk_eq("R8 wcol on busy write", wcol_flag, 1);
        chk_eq("R8 buffer unchanged", txb_q, old_txb);
        guard = 0;
        while (!(scl_oe == 1'b0 && sda_oe == 1'b0) && guard < 2000) begin
            if (scl_oe && !sda_oe) n++;
            @(negedge clk);
            guard++;
        end
        chk_eq("R2 sda release phase", n, exp_rel(dv, held));
        m = 0;
        if (st > 0) pull_scl = 1'b1;
        while (!scl_oe && !sda_oe && guard < 2000) begin
            m++;
            if (m == st + 1) pull_scl = 1'b0;
            @(negedge clk);
            guard++;
        end
        pull_scl = 1'b0;
        chk_eq("R3 R6 high phase", m, exp_high(dv, st));
        k = 0;
        while (!irq_flag && guard < 2000) begin
            if (sda_oe && !scl_oe) k++;
            @(negedge clk);
            guard++;
        end
        chk_eq("R4 sda low phase", k, dv + 1);
        chk_eq("R4 irq set", irq_flag, 1);
        chk_eq("R4 request cleared", ctl_q, 0);
        chk_eq("R4 sda held low", sda_oe, 1);
        chk_eq("R4 scl released", scl_oe, 0);
        chk_eq("R7 no collision", bcol_flag, 0);
        repeat (4) @(negedge clk);
        chk_eq("R5 start seen", start_seen, 1);
        chk_eq("R10 irq sticky", irq_flag, 1);
        clear_flags(3'b101);
        chk_eq("R10 irq cleared", irq_flag, 0);
        chk_eq("R10 wcol cleared", wcol_flag, 0);
    endtask

    task automatic run_coll(input int kind);
        int m, guard;
        div_val = DIV_W'(10);
        write_ctl(5'b00010);
        guard = 0;
        while (!(scl_oe == 1'b0 && sda_oe == 1'b0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (kind == 0) pull_sda = 1'b1;
        m = 0;
        while (!bcol_flag && guard < 2000) begin
            m++;
            if (kind == 1 && m == 6) pull_scl = 1'b1;
            @(negedge clk);
            guard++;
        end
        chk_eq("R7 bus collision flagged", bcol_flag, 1);
        chk_eq("R7 no irq on collision", irq_flag, 0);
        chk_eq("R7 scl released", scl_oe, 0);
        chk_eq("R7 sda released", sda_oe, 0);
        chk_eq("R7 request cleared", ctl_q, 0);
        pull_sda = 1'b0;
        pull_scl = 1'b0;
        repeat (5) @(negedge clk);
        chk_eq("R10 bcol sticky", bcol_flag, 1);
        clear_flags(3'b010);
        chk_eq("R10 bcol cleared", bcol_flag, 0);
    endtask

    initial begin
        wait (cyc >= LIMIT);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("reset scl_oe", scl_oe, 0);
        chk_eq("reset sda_oe", sda_oe, 0);
        chk_eq("reset ctl_q", ctl_q, 0);
        chk_eq("R5 reset start_seen", start_seen, 0);
        chk_eq("R10 reset flags", {irq_flag, bcol_flag, wcol_flag}, 0);

        // R5: external start then stop
        pull_sda = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R5 external start", start_seen, 1);
        pull_sda = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R5 stop clears", start_seen, 0);

        // R1: request refused while another event bit is set
        write_ctl(5'b00001);
        chk_eq("R1 other bit stored", ctl_q, 5'b00001);
        write_ctl(5'b00011);
        chk_eq("R1 request refused", ctl_q, 5'b00001);
        repeat (5) @(negedge clk);
        chk_eq("R1 lines untouched", scl_oe, 0);
        write_ctl(5'b00000);
        chk_eq("R1 cleared", ctl_q, 0);

        // R8: idle buffer write
        txb_wr = 1'b1;
        txb_wdata = 8'h3C;
        @(negedge clk);
        txb_wr = 1'b0;
        chk_eq("R8 idle buffer write", txb_q, 8'h3C);
        chk_eq("R8 no wcol when idle", wcol_flag, 0);

        run_seq(0, 0);
        run_seq(0, 0);
        run_seq(127, 0);
        run_seq(5, 5);
        run_coll(0);
        run_coll(1);
        run_seq(3, 1);

        for (int i = 0; i < 8; i++) begin
            run_seq(int'($urandom % 24), int'($urandom % 5));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule